// File: doc/BRIEF.md
# Edge-Strobed Watchdog Timer

This block watches a processor that proves it is alive by toggling a strobe line. A rising edge and a falling edge both restart the timeout. The timeout is counted in microsecond ticks that the surrounding logic supplies. Its length is one of three values, chosen by a 2-bit select. The select is taken once, on a capture strobe at power-up, and is frozen after that. The count runs only while the "reset released" indication is high. While that indication is low, the count is held at zero. If the timeout passes with no strobe edge, the active-low status output goes low for a fixed number of ticks. The block then starts a new period by itself. There is no input that disables the watchdog.

The controller has three states. IDLE holds the count at zero and waits for release. COUNT counts ticks toward the selected limit. PULSE drives the status output low and counts the pulse length. The transitions are:
- IDLE to COUNT when the release indication is high.
- COUNT to IDLE when the release indication drops.
- COUNT to COUNT with the count cleared on a strobe edge.
- COUNT to PULSE on the tick that completes the period.
- PULSE to COUNT when the pulse completes and the release indication is high.
- PULSE to IDLE when the pulse completes and the release indication is low.

The strobe passes through a two-flop synchroniser before the edge detector, so an edge takes effect about three clocks after the pin changes.

Top module: `strobe_watchdog`

## Requirements
- R1: After reset the status output `wd_n` is high and the controller is in IDLE.
- R2: While `rel_in` is low, ticks are not counted and `wd_n` stays high. When `rel_in` drops during COUNT, the count is cleared, so a full period is needed after release returns.
- R3: In COUNT, `wd_n` falls on exactly the L-th tick after counting began. L is set by the captured select: 2'b00 gives T_SHORT, 2'b01 gives T_MID, and 2'b10 or 2'b11 gives T_LONG.
- R4: A rising or a falling edge of `strobe`, after synchronisation, clears the count. A full L further ticks are then needed before expiry.
- R5: `wd_n` stays low for exactly PULSE ticks. Strobe edges and a low `rel_in` during the pulse do not shorten it.
- R6: When the pulse ends with `rel_in` high, a fresh period of L ticks starts. When it ends with `rel_in` low, the block returns to IDLE and does not expire.
- R7: The select is captured on the first `cap_in` pulse after reset. Later captures and later changes of `tsel` have no effect. With no capture at all, the long timeout is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| strobe | input | 1 | Asynchronous service strobe; either edge restarts |
| tsel | input | 2 | Timeout select: 00 short, 01 mid, 10/11 long |
| rel_in | input | 1 | High once a reset output is released |
| cap_in | input | 1 | Power-up capture strobe for `tsel` |
| wd_n | output | 1 | Active-low timeout status pulse |

## Verification
The bench builds the block with period limits of 5, 8 and 12 ticks and a 3-tick pulse. With these values, every select code can be swept after its own reset, tick by tick, and the exact tick of each expiry can be checked. The small limits also let every path of the state machine be reached within a few hundred ticks: release drop, an edge of either polarity, an edge inside the pulse, and the end of the pulse with and without release. Each select code is also driven with a second, different capture to show that it is ignored, and one run with no capture confirms the long default.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PULSE = 2'd2
    } wd_state_e;

    typedef enum logic [1:0] {
        SEL_SHORT    = 2'b00,
        SEL_MID      = 2'b01,
        SEL_LONG     = 2'b10,
        SEL_LONG_ALT = 2'b11
    } wd_sel_e;
endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic edge_o
);
    // sh[STAGES-1] is the synchronised level, sh[STAGES] its delayed copy
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], strobe};
    end

    assign edge_o = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/wdt_sel_latch.sv
module wdt_sel_latch
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap,
    input  logic [1:0] sel_in,
    output wd_sel_e    sel_q
);
    logic locked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= SEL_LONG;
            locked <= 1'b0;
        end else if (cap && !locked) begin
            sel_q  <= wd_sel_e'(sel_in);
            locked <= 1'b1;
        end
    end

    // R7
    sel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && cap) |=> $stable(sel_q));
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int T_SHORT = 16000,
    parameter int T_MID   = 160000,
    parameter int T_LONG  = 1600000,
    parameter int PULSE   = 128
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  logic    edge_i,
    input  logic    rel,
    input  wd_sel_e sel,
    output logic    wd_n
);
    localparam int MAXV = (T_LONG > PULSE) ? T_LONG : PULSE;
    localparam int CW   = $clog2(MAXV + 1);

    wd_state_e     state, nxt;
    logic [CW-1:0] cnt, limit_m1;

    always_comb begin
        unique case (sel)
            SEL_SHORT:    limit_m1 = CW'(T_SHORT - 1);
            SEL_MID:      limit_m1 = CW'(T_MID - 1);
            SEL_LONG:     limit_m1 = CW'(T_LONG - 1);
            SEL_LONG_ALT: limit_m1 = CW'(T_LONG - 1);
            default:      limit_m1 = CW'(T_LONG - 1);
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (rel) nxt = ST_COUNT;
            ST_COUNT: begin
                if (!rel)
                    nxt = ST_IDLE;
                else if (tick && !edge_i && cnt == limit_m1)
                    nxt = ST_PULSE;
            end
            ST_PULSE: begin
                if (tick && cnt == CW'(PULSE - 1))
                    nxt = rel ? ST_COUNT : ST_IDLE;
            end
            default:  nxt = ST_IDLE;
        endcase
    end

    // Tick counter shared by the period and the pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (nxt != state || state == ST_IDLE)
            cnt <= '0;
        else if (state == ST_COUNT && edge_i)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + CW'(1);
    end

    // Outputs
    always_comb begin
        wd_n = (state != ST_PULSE);
    end

    // R2
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (cnt == '0));
    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT) |-> (cnt <= limit_m1));
    // R4
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && edge_i) |=> (cnt == '0));
    // R5
    pulse_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE) |-> ($past(state) == ST_PULSE || $past(state) == ST_COUNT));
endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog
    import wdt_pkg::*;
#(
    parameter int T_SHORT     = 16000,
    parameter int T_MID       = 160000,
    parameter int T_LONG      = 1600000,
    parameter int PULSE       = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_us,
    input  logic       strobe,
    input  logic [1:0] tsel,
    input  logic       rel_in,
    input  logic       cap_in,
    output logic       wd_n
);
    logic    strobe_edge;
    wd_sel_e sel_q;

    wdt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .edge_o(strobe_edge)
    );

    wdt_sel_latch u_sel (
        .clk(clk), .rst_n(rst_n), .cap(cap_in), .sel_in(tsel), .sel_q(sel_q)
    );

    wdt_core #(
        .T_SHORT(T_SHORT), .T_MID(T_MID), .T_LONG(T_LONG), .PULSE(PULSE)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick_us), .edge_i(strobe_edge),
        .rel(rel_in), .sel(sel_q), .wd_n(wd_n)
    );
endmodule

// File: tb/strobe_watchdog_tb.sv
`timescale 1ns/1ps
module strobe_watchdog_tb;
    localparam int TS = 5, TM = 8, TL = 12, TP = 3;

    logic clk = 0, rst_n = 0, tick = 0, strobe = 0, rel = 0, cap = 0;
    logic [1:0] tsel = 2'b00;
    logic wd_n;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    strobe_watchdog #(.T_SHORT(TS), .T_MID(TM), .T_LONG(TL), .PULSE(TP)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick), .strobe(strobe),
        .tsel(tsel), .rel_in(rel), .cap_in(cap), .wd_n(wd_n)
    );

    function automatic int exp_len(int s);
        return (s == 0) ? TS : (s == 1) ? TM : TL;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1;
        @(negedge clk) tick = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic ticks_expect(input int n, input logic e, input string tag);
        for (int i = 0; i < n; i++) begin
            do_tick();
            chk(wd_n === e, tag, int'(wd_n), int'(e));
        end
    endtask

    task automatic toggle();
        @(negedge clk) strobe = ~strobe;
        repeat (4) @(negedge clk);
    endtask

    task automatic power_up(input int s, input bit do_cap);
        rst_n = 0; rel = 0; cap = 0; strobe = 0; tsel = 2'(s);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        if (do_cap) begin
            cap = 1; @(negedge clk); cap = 0;
            tsel = 2'(s + 1);
            @(negedge clk);
            cap = 1; @(negedge clk); cap = 0;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R3 watchdog expired act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < 4; s++) begin
            int L;
            L = exp_len(s);
            power_up(s, 1);
            chk(wd_n === 1'b1, "R1 reset state", int'(wd_n), 1);
            ticks_expect(TL + 2, 1'b1, "R2 idle no expiry");
            rel = 1; repeat (2) @(negedge clk);
            ticks_expect(L - 1, 1'b1, "R3 R7 counting");
            ticks_expect(1, 1'b0, "R3 R7 expiry tick");
            ticks_expect(TP - 1, 1'b0, "R5 pulse low");
            toggle();
            chk(wd_n === 1'b0, "R5 edge inside pulse", int'(wd_n), 0);
            ticks_expect(1, 1'b1, "R5 pulse end");
            ticks_expect(L - 1, 1'b1, "R6 fresh period");
            ticks_expect(1, 1'b0, "R6 second expiry");
            ticks_expect(TP - 1, 1'b0, "R5 second pulse");
            ticks_expect(1, 1'b1, "R5 second pulse end");
            ticks_expect(L - 1, 1'b1, "R4 before edge");
            toggle();
            ticks_expect(L - 1, 1'b1, "R4 after falling edge");
            toggle();
            ticks_expect(L - 1, 1'b1, "R4 after rising edge");
            ticks_expect(1, 1'b0, "R4 expiry after edges");
            ticks_expect(TP - 1, 1'b0, "R5 pulse");
            ticks_expect(1, 1'b1, "R5 pulse end");
            ticks_expect(L - 1, 1'b1, "R2 before release drop");
            rel = 0; repeat (2) @(negedge clk);
            rel = 1; repeat (2) @(negedge clk);
            ticks_expect(L - 1, 1'b1, "R2 count cleared");
            ticks_expect(1, 1'b0, "R2 full period expiry");
            rel = 0;
            ticks_expect(TP - 1, 1'b0, "R5 pulse with release low");
            ticks_expect(1, 1'b1, "R5 pulse end release low");
            ticks_expect(TL + 2, 1'b1, "R6 idle after pulse");
        end
        power_up(0, 0);
        rel = 1; repeat (2) @(negedge clk);
        ticks_expect(TL - 1, 1'b1, "R7 default long counting");
        ticks_expect(1, 1'b0, "R7 default long expiry");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule